// File: doc/BRIEF.md
# Two-Wire Serial Target with Register Pointer

This block sits between a two-wire serial bus (SCL clock, SDA data) and a small register file inside the chip. SCL and SDA each pass through a two-flop synchroniser and a glitch filter. The block then finds the bus frame markers, compares the incoming 7-bit device address with one of two values picked by a strap input, and acknowledges the bytes meant for it. The block never drives SDA high. It only asserts an open-drain enable that pulls the line low.

A write transfer carries the device address with the direction bit clear, a pointer byte, and any number of data bytes. Each data byte appears at the register port as a one-cycle strobe, with the pointer as the address. The pointer then advances and wraps from 0xFF to 0x00.

A read first sets the pointer with a write frame. A repeated start with the direction bit set follows. The block then shifts register contents out from the pointer, advancing after each byte, until the controller answers a byte with NACK.

Top module: `i2c_reg_target`

The controller FSM has these states:
- ST_IDLE: bus released; the block waits for a start.
- ST_ADDR: shifting in the address byte.
- ST_ADDR_ACK: acknowledge slot for the address.
- ST_PTR: shifting in the pointer byte.
- ST_PTR_ACK: acknowledge slot for the pointer.
- ST_WR: shifting in a data byte.
- ST_WR_ACK: acknowledge slot for a data byte.
- ST_RD: shifting a data byte out.
- ST_RD_ACK: the controller's acknowledge slot.

The transitions are as follows:
- A start moves any state to ST_ADDR. A stop moves any state to ST_IDLE.
- ST_ADDR goes to ST_ADDR_ACK on a match, or to ST_IDLE on a mismatch.
- ST_ADDR_ACK goes to ST_RD when the direction bit is 1, or to ST_PTR when it is 0.
- ST_PTR goes to ST_PTR_ACK, then to ST_WR.
- ST_WR and ST_WR_ACK alternate.
- ST_RD goes to ST_RD_ACK. ST_RD_ACK goes back to ST_RD on ACK, or to ST_IDLE on NACK.

The ST_ADDR, ST_PTR, ST_WR and ST_RD_ACK states sample SDA on the SCL rising edge. Every state leaves on the SCL falling edge after its last bit.

## Requirements
- R1: An SDA falling edge while SCL is high (start) restarts address reception from any state, including in the middle of a write transfer (repeated start).
- R2: The 7-bit device address is 0x6A when `addr_sel` is 0 and 0x6B when it is 1. It is carried in bits 7..1 of the first byte, sent MSB first, and bit 0 is the direction bit (1 = read). A matching address is acknowledged by pulling SDA low during the ninth clock.
- R3: After a non-matching address, the block does not pull SDA low and produces no register write until the next start.
- R4: The second byte of a write transfer loads the register pointer and is acknowledged.
- R5: Each following data byte is acknowledged and produces `reg_wr` high for exactly one cycle, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. The pointer then increments and wraps from 0xFF to 0x00.
- R6: In a read transfer, the block sends `reg_rdata` for the pointer MSB first. The value is captured when the byte starts, and the pointer increments after each byte, with wrap.
- R7: A NACK from the controller after a read byte ends the read, and SDA stays released until the next start or stop.
- R8: A stop (SDA rising edge while SCL is high) returns the block to idle, and clocked bits after it without a start are not acknowledged.
- R9: SDA is open-drain. `sda_oe` only pulls the line low, and it is 0 out of reset.
- R10: `sda_oe` changes only while the filtered SCL is low.
- R11: A pulse on SCL or SDA shorter than `FILT_LEN` system clocks is ignored and does not disturb a transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x the bus bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel | input | 1 | Address strap: 0 selects 0x6A, 1 selects 0x6B |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_addr | output | 8 | Register pointer, used for both reads and writes |
| reg_wdata | output | 8 | Write data, valid while reg_wr is high |
| reg_rdata | input | 8 | Register contents at reg_addr |

## Verification
The bench sweeps addresses 0x68 to 0x6F under both strap values. A wrong compare would acknowledge a neighbour's address, or miss its own. Frames to foreign addresses carry full pointer and data bytes, so a design that keeps listening after a mismatch would show up as a stray write. Writes and reads cross the 0xFF-to-0x00 pointer boundary, where a pointer that does not wrap, or that advances at the wrong moment, returns shifted data. Other tests cover a repeated start in the middle of a write, a NACK followed by idle clocks, bits clocked after a stop, and short glitches on both lines. A design that fails any of these would leave SDA pulled low, acknowledge data it should ignore, or take a spurious SCL edge as a bit.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } tgt_state_e;
endpackage

// File: rtl/line_filter.sv
module line_filter #(
    parameter int SYNC_LEN = 2,
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [SYNC_LEN-1:0] sync_q;
    logic [FILT_LEN-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            hist_q <= '1;
            dout   <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_LEN-2:0], din};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_LEN-1]};
            if (&hist_q)
                dout <= 1'b1;
            else if (~|hist_q)
                dout <= 1'b0;
        end
    end
endmodule

// File: rtl/bus_events.sv
module bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);
    logic scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_f;
            sda_d <= sda_f;
        end
    end

    assign scl_rise = scl_f & ~scl_d;
    assign scl_fall = ~scl_f & scl_d;
    assign start_c  = scl_f & scl_d & sda_d & ~sda_f;
    assign stop_c   = scl_f & scl_d & ~sda_d & sda_f;
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR_LO = 7'h6A,
    parameter logic [6:0] DEV_ADDR_HI = 7'h6B,
    parameter int         SYNC_LEN    = 2,
    parameter int         FILT_LEN    = 4,
    parameter int         BYTE_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              addr_sel,
    output logic              sda_oe,
    output logic              reg_wr,
    output logic [BYTE_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    input  logic [BYTE_W-1:0] reg_rdata
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    logic [1:0] raw_lines, filt_lines;
    logic scl_f, sda_f;
    logic scl_rise, scl_fall, start_c, stop_c;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_filt
        line_filter #(.SYNC_LEN(SYNC_LEN), .FILT_LEN(FILT_LEN)) u_filt (
            .clk (clk),
            .rst_n(rst_n),
            .din (raw_lines[g]),
            .dout(filt_lines[g])
        );
    end
    assign scl_f = filt_lines[1];
    assign sda_f = filt_lines[0];

    bus_events u_ev (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f   (scl_f),
        .sda_f   (sda_f),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall),
        .start_c (start_c),
        .stop_c  (stop_c)
    );

    tgt_state_e        state, state_n;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg, ptr;
    logic              rd_mode, mack;
    logic              byte_done, addr_hit;
    logic [6:0]        dev_addr;

    assign dev_addr  = addr_sel ? DEV_ADDR_HI : DEV_ADDR_LO;
    assign addr_hit  = (shreg[BYTE_W-1:1] == dev_addr);
    assign byte_done = scl_fall && (cnt == CNT_FULL);
    assign reg_addr  = ptr;
    assign reg_wdata = shreg;

    // next-state logic
    always_comb begin
        state_n = state;
        if (start_c)
            state_n = ST_ADDR;
        else if (stop_c)
            state_n = ST_IDLE;
        else begin
            unique case (state)
                ST_IDLE:     state_n = ST_IDLE;
                ST_ADDR:     if (byte_done) state_n = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (scl_fall) state_n = rd_mode ? ST_RD : ST_PTR;
                ST_PTR:      if (byte_done) state_n = ST_PTR_ACK;
                ST_PTR_ACK:  if (scl_fall) state_n = ST_WR;
                ST_WR:       if (byte_done) state_n = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) state_n = ST_WR;
                ST_RD:       if (scl_fall && cnt == CNT_LAST) state_n = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) state_n = mack ? ST_RD : ST_IDLE;
                default:     state_n = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_n;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            shreg   <= '0;
            ptr     <= '0;
            rd_mode <= 1'b0;
            mack    <= 1'b0;
            sda_oe  <= 1'b0;
            reg_wr  <= 1'b0;
        end else begin
            reg_wr <= 1'b0;
            if (start_c || stop_c) begin
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_PTR, ST_WR: begin
                        if (scl_rise) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_f};
                            cnt   <= cnt + 1'b1;
                        end
                        if (byte_done) begin
                            cnt <= '0;
                            if (state == ST_ADDR) begin
                                rd_mode <= shreg[0];
                                sda_oe  <= addr_hit;
                            end else begin
                                sda_oe <= 1'b1;
                                if (state == ST_PTR)
                                    ptr <= shreg;
                                else
                                    reg_wr <= 1'b1;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (rd_mode) begin
                                shreg  <= reg_rdata;
                                sda_oe <= ~reg_rdata[BYTE_W-1];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_PTR_ACK: if (scl_fall) sda_oe <= 1'b0;
                    ST_WR_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            ptr    <= ptr + 1'b1;
                        end
                    end
                    ST_RD: begin
                        if (scl_fall) begin
                            if (cnt == CNT_LAST) begin
                                sda_oe <= 1'b0;
                                ptr    <= ptr + 1'b1;
                                cnt    <= '0;
                            end else begin
                                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~shreg[BYTE_W-2];
                                cnt    <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise)
                            mack <= ~sda_f;
                        if (scl_fall && mack) begin
                            shreg  <= reg_rdata;
                            sda_oe <= ~reg_rdata[BYTE_W-1];
                            cnt    <= '0;
                        end
                    end
                    ST_IDLE: sda_oe <= 1'b0;
                    default: sda_oe <= 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk
    import i2c_tgt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_f,
    input logic       sda_oe,
    input logic       reg_wr,
    input tgt_state_e state
);
    // R10
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_f);

    // R5
    wr_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    // R5
    wr_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> state == ST_WR_ACK);

    // R3
    idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> !sda_oe);

    // R2
    oe_rise_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> (state == ST_ADDR_ACK || state == ST_PTR_ACK ||
                           state == ST_WR_ACK || state == ST_RD));
endmodule

bind i2c_reg_target i2c_reg_target_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_f (scl_f),
    .sda_oe(sda_oe),
    .reg_wr(reg_wr),
    .state (state)
);

// File: tb/sim_i2c_reg_target.sv
module sim_i2c_reg_target;
    localparam int Q = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_drv = 1'b1;
    logic sda_drv = 1'b1;
    logic addr_sel = 1'b0;
    logic sda_oe, reg_wr;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic sda_line;

    logic [7:0] mem  [256];
    logic [7:0] gold [256];

    int total = 0;
    int fails = 0;
    int wr_count = 0;
    int oe_bad = 0;
    logic oe_prev = 1'b0;
    logic wr_prev = 1'b0;
    int wr_long = 0;

    always #2.5 clk = ~clk;

    assign sda_line  = sda_drv & ~sda_oe;
    assign reg_rdata = mem[reg_addr];

    i2c_reg_target u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_drv),
        .sda_i    (sda_line),
        .addr_sel (addr_sel),
        .sda_oe   (sda_oe),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    always @(posedge clk) begin
        if (reg_wr) begin
            mem[reg_addr] <= reg_wdata;
            wr_count <= wr_count + 1;
        end
        if (rst_n && (sda_oe != oe_prev) && scl_drv) oe_bad <= oe_bad + 1;
        if (reg_wr && wr_prev) wr_long <= wr_long + 1;
        oe_prev <= sda_oe;
        wr_prev <= reg_wr;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clock_bit(input logic b, output logic seen);
        sda_drv = b;
        wt(Q);
        scl_drv = 1'b1;
        wt(Q);
        seen = sda_line;
        wt(Q);
        scl_drv = 1'b0;
        wt(Q);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1;
        wt(Q);
        scl_drv = 1'b1;
        wt(Q);
        sda_drv = 1'b0;
        wt(Q);
        scl_drv = 1'b0;
        wt(Q);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0;
        wt(Q);
        scl_drv = 1'b1;
        wt(Q);
        sda_drv = 1'b1;
        wt(Q);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        clock_bit(1'b1, s);
        acked = ~s;
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            d[i] = s;
        end
        clock_bit(~give_ack, s);
    endtask

    function automatic logic [7:0] pat(input int k);
        return 8'((k * 37 + 11) ^ 8'h5A);
    endfunction

    // write n bytes from pointer p using device address a
    task automatic write_run(input logic [6:0] a, input logic [7:0] p, input int n, input int seed);
        logic ak;
        bus_start();
        put_byte({a, 1'b0}, ak);
        chk(ak, "R2 address ack", ak, 1);
        put_byte(p, ak);
        chk(ak, "R4 pointer ack", ak, 1);
        for (int k = 0; k < n; k++) begin
            put_byte(pat(seed + k), ak);
            chk(ak, "R5 data ack", ak, 1);
            gold[8'(p + k)] = pat(seed + k);
        end
        bus_stop();
    endtask

    task automatic read_run(input logic [6:0] a, input logic [7:0] p, input int n);
        logic ak;
        logic [7:0] d;
        logic s;
        bus_start();
        put_byte({a, 1'b0}, ak);
        put_byte(p, ak);
        bus_start();
        put_byte({a, 1'b1}, ak);
        chk(ak, "R6 read address ack", ak, 1);
        for (int k = 0; k < n; k++) begin
            get_byte(k != n - 1, d);
            chk(d == gold[8'(p + k)], "R6 read data", d, gold[8'(p + k)]);
        end
        clock_bit(1'b1, s);
        chk(s == 1'b1 && sda_oe == 1'b0, "R7 released after NACK", s, 1);
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic ak, s;
        int wc;
        for (int i = 0; i < 256; i++) begin
            mem[i]  = 8'(i ^ 8'hC3);
            gold[i] = 8'(i ^ 8'hC3);
        end
        wt(10);
        chk(sda_oe == 1'b0, "R9 reset oe", sda_oe, 0);
        chk(reg_wr == 1'b0, "R9 reset wr", reg_wr, 0);
        rst_n = 1'b1;
        wt(20);

        // R2/R3 sweep: both straps, addresses 0x68..0x6F
        for (int sel = 0; sel < 2; sel++) begin
            addr_sel = sel[0];
            wt(Q);
            for (int a = 8'h68; a <= 8'h6F; a++) begin
                logic want;
                want = (a == (sel != 0 ? 8'h6B : 8'h6A));
                wc = wr_count;
                bus_start();
                put_byte({a[6:0], 1'b0}, ak);
                chk(ak == want, "R2 address match", ak, want);
                put_byte(8'h40, ak);
                chk(ak == want, "R3 pointer ack follows match", ak, want);
                put_byte(pat(a), ak);
                chk(ak == want, "R3 data ack follows match", ak, want);
                bus_stop();
                if (want) gold[8'h40] = pat(a);
                chk((wr_count - wc) == (want ? 1 : 0), "R3 write count", wr_count - wc, want ? 1 : 0);
                chk(mem[8'h40] == gold[8'h40], "R3 register content", mem[8'h40], gold[8'h40]);
            end
        end

        addr_sel = 1'b0;
        wt(Q);
        // R5 sequential write then R6 read back
        wc = wr_count;
        write_run(7'h6A, 8'h10, 6, 100);
        chk(wr_count - wc == 6, "R5 strobe count", wr_count - wc, 6);
        for (int k = 0; k < 6; k++)
            chk(mem[8'h10 + k] == gold[8'h10 + k], "R5 written value", mem[8'h10 + k], gold[8'h10 + k]);
        read_run(7'h6A, 8'h10, 6);

        // R5 wrap on write, R6 wrap on read
        addr_sel = 1'b1;
        wt(Q);
        write_run(7'h6B, 8'hFE, 3, 200);
        chk(mem[8'h00] == gold[8'h00], "R5 pointer wrap write", mem[8'h00], gold[8'h00]);
        chk(mem[8'hFF] == gold[8'hFF], "R5 write at 0xFF", mem[8'hFF], gold[8'hFF]);
        read_run(7'h6B, 8'hFF, 2);

        // R1 repeated start in the middle of a write
        bus_start();
        put_byte({7'h6B, 1'b0}, ak);
        put_byte(8'h80, ak);
        bus_start();
        put_byte({7'h6B, 1'b0}, ak);
        chk(ak, "R1 restart address ack", ak, 1);
        put_byte(8'h90, ak);
        put_byte(pat(7), ak);
        gold[8'h90] = pat(7);
        bus_stop();
        chk(mem[8'h90] == gold[8'h90], "R1 write after restart", mem[8'h90], gold[8'h90]);

        // R8 bits after stop are not acknowledged
        wc = wr_count;
        scl_drv = 1'b0;
        wt(Q);
        put_byte({7'h6B, 1'b0}, ak);
        chk(!ak, "R8 no ack without start", ak, 0);
        put_byte(8'h33, ak);
        chk(wr_count == wc, "R8 no write after stop", wr_count - wc, 0);
        sda_drv = 1'b1;
        wt(Q);
        scl_drv = 1'b1;
        wt(Q);

        // R11 glitches on SCL (low phase) and SDA (high phase)
        bus_start();
        put_byte({7'h6B, 1'b0}, ak);
        put_byte(8'h55, ak);
        sda_drv = 1'b0;
        wt(Q);
        scl_drv = 1'b1;
        wt(2);
        scl_drv = 1'b0;
        wt(Q);
        begin
            logic [7:0] v;
            v = pat(9);
            for (int i = 7; i >= 0; i--) begin
                sda_drv = v[i];
                wt(Q);
                scl_drv = 1'b1;
                wt(Q / 2);
                if (i == 4) begin
                    sda_drv = ~v[i];
                    wt(2);
                    sda_drv = v[i];
                end
                wt(Q / 2);
                wt(Q);
                scl_drv = 1'b0;
                wt(Q);
            end
            clock_bit(1'b1, s);
            chk(!s, "R11 ack despite glitches", s, 0);
            gold[8'h55] = v;
        end
        bus_stop();
        chk(mem[8'h55] == gold[8'h55], "R11 glitch-free data", mem[8'h55], gold[8'h55]);

        wt(Q);
        chk(oe_bad == 0, "R10 oe moved while SCL high", oe_bad, 0);
        chk(wr_long == 0, "R5 strobe longer than one cycle", wr_long, 0);
        chk(sda_oe == 1'b0, "R9 released at end", sda_oe, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule